// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table in memory. A translation request carries the virtual address and whether the access is a read or a write. The walker reads a first-level entry found through a table base register, then reads a second-level (leaf) entry, and returns either the physical address or a fault. The fault is tagged with the table level where it arose and with its cause.

The virtual address is cut into a 10-bit first-level index in bits 31:22, a 10-bit second-level index in bits 21:12 and a 12-bit page offset. Each table is one 4 KB page of 1024 four-byte entries. An entry holds a 20-bit frame number in bits 31:12, a valid flag in bit 0, read permission in bit 1 and write permission in bit 2. Privileged software loads the base register through its own write port, for example on a context switch. Memory is reached through a single read port that has at most one read outstanding.

The walker handles one request at a time. It does no caching and never writes to the tables.

Top module: `ptw_top`

## Requirements
- R1: After reset `reqReady` is 1, and `rspValid` and `memReqValid` are 0.
- R2: The first read goes to base + 4 × vaddr[31:22]. The second read goes to {first-level entry[31:12], vaddr[21:12], 2'b00}.
- R3: When both entries are valid and the leaf permits the access, the response has `rspFault` = 0 and `rspPaddr` = {leaf[31:12], vaddr[11:0]}.
- R4: If bit 0 of the first-level entry is 0, the response has `rspFault` = 1, `rspFaultLevel` = 0 (first level), `rspFaultCause` = 0 (invalid) and `rspPaddr` = 0. Exactly one memory read is made for that request.
- R5: If bit 0 of the leaf entry is 0, the response has `rspFault` = 1, `rspFaultLevel` = 1 (second level), `rspFaultCause` = 0 and `rspPaddr` = 0.
- R6: A read needs leaf bit 1 and a write needs leaf bit 2. A valid leaf that lacks the needed bit gives `rspFault` = 1, `rspFaultLevel` = 1, `rspFaultCause` = 1 (permission) and `rspPaddr` = 0.
- R7: `reqReady` is high only while the walker is idle. A request presented while a walk is running is ignored and gets no response.
- R8: Each accepted request gets exactly one response, and `rspValid` is high for exactly one cycle.
- R9: `baseWrEn` may load the base register at any time. A walk uses the base value that was held when its request was accepted, and later walks use the new value.
- R10: `memReqValid` stays high with a stable `memReqAddr` until `memReqReady` is seen. No new read is issued until the previous read's data has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseWrEn | input | 1 | Privileged write strobe for the table base register |
| baseWrData | input | 32 | New table base address |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to accept a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| rspValid | output | 1 | One-cycle response strobe |
| rspPaddr | output | 32 | Physical address, or 0 on a fault |
| rspFault | output | 1 | Translation failed |
| rspFaultLevel | output | 1 | 0 = first level, 1 = second level |
| rspFaultCause | output | 1 | 0 = invalid entry, 1 = permission |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Memory read byte address |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Table entry read from memory |

## Verification
The bench goes after the early exit on an invalid first-level entry. A walker that read the second level anyway would show two memory reads, or would report a second-level fault. Read and write requests are run against leaves that carry only one of the two permission bits. A design that checked the wrong bit, or skipped the check, would return an address where a permission fault is due. The bench also places the highest indices and an all-ones offset at both levels, to catch a shift or concatenation error in the address. It stalls the memory handshake and rewrites the base register in the middle of a walk. These runs show whether the walker drops a read, issues a read twice, or picks up the new base too early.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;

  typedef enum logic { LVL_FIRST = 1'b0, LVL_SECOND = 1'b1 } fault_lvl_e;
  typedef enum logic { CAUSE_INVALID = 1'b0, CAUSE_PERM = 1'b1 } fault_cause_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_L1, ST_WAIT_L1, ST_READ_L2, ST_WAIT_L2, ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic         capReq;
    logic         capL1;
    logic         capLeaf;
    logic         setFault;
    logic         selL2;
    fault_lvl_e   faultLvl;
    fault_cause_e faultCause;
  } walk_stb_t;
endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter logic [ADDR_W-1:0] BASE_RST = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  walk_stb_t         stb,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              entryValid,
  output logic              permOk,
  output logic [ADDR_W-1:0] paddr,
  output logic              fault,
  output logic              faultLvl,
  output logic              faultCause
);
  localparam int IDX2_W  = OFF_W - 2;
  localparam int IDX1_W  = ADDR_W - OFF_W - IDX2_W;
  localparam int FRAME_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0]  baseReg;
  logic [ADDR_W-1:0]  vaReg;
  logic               wrReg;
  logic [ADDR_W-1:0]  l1AddrReg;
  logic [FRAME_W-1:0] l1Frame;

  wire [IDX1_W-1:0] reqIdx1 = reqVaddr[ADDR_W-1 -: IDX1_W];
  wire [IDX2_W-1:0] vaIdx2  = vaReg[OFF_W +: IDX2_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg    <= BASE_RST;
      vaReg      <= '0;
      wrReg      <= 1'b0;
      l1AddrReg  <= '0;
      l1Frame    <= '0;
      paddr      <= '0;
      fault      <= 1'b0;
      faultLvl   <= 1'b0;
      faultCause <= 1'b0;
    end else begin
      if (baseWrEn) baseReg <= baseWrData;
      if (stb.capReq) begin
        vaReg     <= reqVaddr;
        wrReg     <= reqWrite;
        l1AddrReg <= baseReg + {{(ADDR_W-IDX1_W-2){1'b0}}, reqIdx1, 2'b00};
      end
      if (stb.capL1) l1Frame <= memRspData[ADDR_W-1 -: FRAME_W];
      if (stb.capLeaf) begin
        paddr <= {memRspData[ADDR_W-1 -: FRAME_W], vaReg[OFF_W-1:0]};
        fault <= 1'b0;
      end else if (stb.setFault) begin
        paddr      <= '0;
        fault      <= 1'b1;
        faultLvl   <= stb.faultLvl;
        faultCause <= stb.faultCause;
      end
    end
  end

  assign memReqAddr = stb.selL2 ? {l1Frame, vaIdx2, 2'b00} : l1AddrReg;
  assign entryValid = memRspData[BIT_V];
  assign permOk     = wrReg ? memRspData[BIT_W] : memRspData[BIT_R];

  // R4/R5/R6: a fault always leaves a zero address behind
  p_fault_zero_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.setFault |=> (fault && paddr == '0));
endmodule

// File: rtl/ptw_control.sv
module ptw_control
  import ptw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      rspValid,
  output logic      memReqValid,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  logic      entryValid,
  input  logic      permOk,
  output walk_stb_t stb
);
  walk_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    stb         = '0;
    reqReady    = 1'b0;
    rspValid    = 1'b0;
    memReqValid = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.capReq = 1'b1;
          nextState  = ST_READ_L1;
        end
      end
      ST_READ_L1: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_WAIT_L1;
      end
      ST_WAIT_L1: begin
        if (memRspValid) begin
          if (entryValid) begin
            stb.capL1 = 1'b1;
            nextState = ST_READ_L2;
          end else begin
            stb.setFault   = 1'b1;
            stb.faultLvl   = LVL_FIRST;
            stb.faultCause = CAUSE_INVALID;
            nextState      = ST_DONE;
          end
        end
      end
      ST_READ_L2: begin
        stb.selL2   = 1'b1;
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_WAIT_L2;
      end
      ST_WAIT_L2: begin
        stb.selL2 = 1'b1;
        if (memRspValid) begin
          nextState = ST_DONE;
          if (!entryValid) begin
            stb.setFault   = 1'b1;
            stb.faultLvl   = LVL_SECOND;
            stb.faultCause = CAUSE_INVALID;
          end else if (!permOk) begin
            stb.setFault   = 1'b1;
            stb.faultLvl   = LVL_SECOND;
            stb.faultCause = CAUSE_PERM;
          end else begin
            stb.capLeaf = 1'b1;
          end
        end
      end
      ST_DONE: begin
        rspValid  = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  p_no_read_in_flight_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic              rspFault,
  output logic              rspFaultLevel,
  output logic              rspFaultCause,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData
);
  walk_stb_t stb;
  logic entryValid, permOk;

  ptw_control u_ctrl (
    .clk, .rstN, .reqValid, .reqReady, .rspValid,
    .memReqValid, .memReqReady, .memRspValid,
    .entryValid, .permOk, .stb
  );

  ptw_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dp (
    .clk, .rstN, .stb, .baseWrEn, .baseWrData, .reqVaddr, .reqWrite,
    .memRspData, .memReqAddr, .entryValid, .permOk,
    .paddr(rspPaddr), .fault(rspFault),
    .faultLvl(rspFaultLevel), .faultCause(rspFaultCause)
  );

  p_memreq_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));
endmodule

// File: tb/tb_ptw_top.sv
module tb_ptw_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        fault;
    logic        lvl;
    logic        cause;
    logic [31:0] pa;
    logic [1:0]  reads;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h00403123, 1'b0, 1'b0, 1'b0, 1'b0, 32'hABCDE123, 2'd2},
    '{32'h00403FFF, 1'b1, 1'b0, 1'b0, 1'b0, 32'hABCDEFFF, 2'd2},
    '{32'h00404000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h12345000, 2'd2},
    '{32'h00404ABC, 1'b1, 1'b1, 1'b1, 1'b1, 32'h00000000, 2'd2},
    '{32'h00405010, 1'b0, 1'b1, 1'b1, 1'b0, 32'h00000000, 2'd2},
    '{32'h00406777, 1'b1, 1'b0, 1'b0, 1'b0, 32'h55555777, 2'd2},
    '{32'h00406777, 1'b0, 1'b1, 1'b1, 1'b1, 32'h00000000, 2'd2},
    '{32'h00800000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 2'd1},
    '{32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 2'd2},
    '{32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 2'd2}
  };

  logic clk = 0, rstN = 0;
  logic baseWrEn = 0; logic [31:0] baseWrData = '0;
  logic reqValid = 0, reqReady, reqWrite = 0; logic [31:0] reqVaddr = '0;
  logic rspValid, rspFault, rspFaultLevel, rspFaultCause; logic [31:0] rspPaddr;
  logic memReqValid, memReqReady = 1; logic [31:0] memReqAddr;
  logic memRspValid = 0; logic [31:0] memRspData = '0;

  logic [31:0] mem [int unsigned];
  int readCount = 0;
  logic [31:0] readAddr [2];
  logic stall = 0;
  int checks = 0, fails = 0;
  logic gotFault, gotLvl, gotCause; logic [31:0] gotPa; int gotRsp;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_top dut (.*);

  always @(posedge clk) begin
    memReqReady <= stall ? ~memReqReady : 1'b1;
    memRspValid <= 1'b0;
    if (memReqValid && memReqReady) begin
      memRspValid <= 1'b1;
      memRspData  <= mem.exists(memReqAddr) ? mem[memReqAddr] : 32'h0;
      if (readCount < 2) readAddr[readCount] <= memReqAddr;
      readCount <= readCount + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setBase(input logic [31:0] b);
    @(negedge clk); baseWrEn = 1; baseWrData = b;
    @(negedge clk); baseWrEn = 0;
  endtask

  // starts a walk; returns at the negedge after acceptance
  task automatic startWalk(input logic [31:0] va, input logic wr);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    readCount = 0;
    reqValid = 1; reqVaddr = va; reqWrite = wr;
    @(negedge clk); reqValid = 0;
  endtask

  task automatic waitRsp();
    gotRsp = 0;
    for (int i = 0; i < 60 && gotRsp == 0; i++) begin
      if (rspValid) begin
        gotRsp = 1; gotPa = rspPaddr; gotFault = rspFault;
        gotLvl = rspFaultLevel; gotCause = rspFaultCause;
      end else @(negedge clk);
    end
    check(gotRsp == 1, "R8 response seen", gotRsp, 1);
    @(negedge clk);
    check(!rspValid, "R8 single-cycle response", rspValid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    mem[32'h00100004] = 32'h00200001;
    mem[32'h0020000C] = 32'hABCDE007;
    mem[32'h00200010] = 32'h12345003;
    mem[32'h00200014] = 32'h00000006;
    mem[32'h00200018] = 32'h55555005;
    mem[32'h00100FFC] = 32'h00300001;
    mem[32'h00300FFC] = 32'hFFFFF007;
    mem[32'h00400004] = 32'h00500001;
    mem[32'h0050000C] = 32'h77777003;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(reqReady == 1, "R1 reqReady", reqReady, 1);
    check(rspValid == 0, "R1 rspValid", rspValid, 0);
    check(memReqValid == 0, "R1 memReqValid", memReqValid, 0);
    rstN = 1;
    setBase(32'h00100000);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = VECS[v].fault ? (VECS[v].lvl ? (VECS[v].cause ? "R6" : "R5") : "R4") : "R3";
      startWalk(VECS[v].va, VECS[v].wr);
      waitRsp();
      check(gotFault == VECS[v].fault, {tag, " fault flag"}, gotFault, VECS[v].fault);
      check(gotPa == VECS[v].pa, {tag, " paddr"}, gotPa, VECS[v].pa);
      if (VECS[v].fault) begin
        check(gotLvl == VECS[v].lvl, {tag, " level"}, gotLvl, VECS[v].lvl);
        check(gotCause == VECS[v].cause, {tag, " cause"}, gotCause, VECS[v].cause);
      end
      check(readCount == VECS[v].reads, {tag, " read count"}, readCount, VECS[v].reads);
      check(readAddr[0] == 32'h00100000 + {20'h0, VECS[v].va[31:22], 2'b00},
            "R2 first-level address", readAddr[0], 32'h00100000 + {20'h0, VECS[v].va[31:22], 2'b00});
      if (v == 0)
        check(readAddr[1] == 32'h0020000C, "R2 second-level address", readAddr[1], 32'h0020000C);
    end

    // R7: request during a walk is ignored
    startWalk(32'h00403123, 1'b0);
    reqValid = 1; reqVaddr = 32'h00800000;
    check(reqReady == 0, "R7 busy not ready", reqReady, 0);
    @(negedge clk);
    check(reqReady == 0, "R7 busy not ready", reqReady, 0);
    reqValid = 0;
    waitRsp();
    check(gotPa == 32'hABCDE123 && !gotFault, "R7 first request kept", gotPa, 32'hABCDE123);
    repeat (8) @(negedge clk);
    check(!rspValid && reqReady, "R7 no second response", rspValid, 0);

    // R9: base switch and mid-walk base write
    setBase(32'h00400000);
    startWalk(32'h00403123, 1'b0);
    baseWrEn = 1; baseWrData = 32'h00100000;
    @(negedge clk); baseWrEn = 0;
    waitRsp();
    check(gotPa == 32'h77777123, "R9 walk keeps base at accept", gotPa, 32'h77777123);
    startWalk(32'h00403123, 1'b0);
    waitRsp();
    check(gotPa == 32'hABCDE123, "R9 next walk uses new base", gotPa, 32'hABCDE123);

    // R10: memory backpressure
    stall = 1;
    startWalk(32'hFFFFFFFF, 1'b1);
    waitRsp();
    check(gotPa == 32'hFFFFFFFF && !gotFault, "R10 stalled walk paddr", gotPa, 32'hFFFFFFFF);
    check(readCount == 2, "R10 stalled read count", readCount, 2);
    startWalk(32'h00800000, 1'b0);
    waitRsp();
    check(readCount == 1 && gotFault && !gotLvl, "R10 stalled early fault", readCount, 1);
    stall = 0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule